// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-mode state machine of a small system-on-chip. After hardware reset it brings the chip to run. A wait-for-interrupt request parks the CPU in idle, where only the CPU clock stops. A software force-sleep request, or a supply or battery fault, takes the chip through an orderly sleep entry: the memory controller is asked to put DRAM into self-refresh, and once it acknowledges, every clock is gated and the external regulator enable is dropped.

Wake-up comes from GPIO wake lines, an RTC alarm or a qualified interrupt. After a battery-fault sleep only the two lowest GPIO wake lines count. The wake sequence optionally waits for the fast oscillator to settle, raises the regulator enable, waits a settle time and returns to run. A fault during that sequence sends the chip back to sleep. An abort-enable bit changes how faults are handled: instead of sleeping at once, the block flags an imprecise data abort so that software can perform the sleep entry itself. A small register set holds the control, configuration and sticky cause bits.

Top module: `pms_sequencer`

## Requirements
- R1: While `rst_n` is low, `mode` is 0 (hardware reset), both clock enables are 0, `pwr_en` is 1 and all registers read 0. One clock edge after `rst_n` rises, `mode` is 1 (run). The mode codes are 0 reset, 1 run, 2 idle, 3 sleep-entry, 4 sleep, 5 oscillator wait and 6 power settle.
- R2: In run, `wfi_req` moves the block to idle at the next edge. Idle has `cpu_clk_en` at 0 and `per_clk_en` at 1. In idle, `irq_pending` returns the block to run at the next edge. In run, `irq_pending` has no effect.
- R3: Sleep entry (mode 3) starts on one of two conditions. The first is the force-sleep bit (register 0 bit 1) while in run. The second is a fault pin low while in run or idle with the abort-enable bit (register 0 bit 0) at 0. During sleep entry `sr_req` is 1 and `cpu_clk_en` is 0, and the block waits for `sr_ack` before entering sleep. The force-sleep bit reads back 0 once sleep entry starts.
- R4: In sleep, `cpu_clk_en`, `per_clk_en` and `pwr_en` are 0 and `sr_req` stays 1. In sleep only, `osc_pd`, `card_float` and `cs_float` follow configuration register 1 bits 0, 1 and 2. In every other mode they are 0.
- R5: With abort-enable at 1, a fault that first asserts while in run or idle pulses `abort_req` for exactly one cycle, one edge later, and starts no sleep entry. From idle this also returns the block to run.
- R6: Sleep is left when any GPIO wake line, `rtc_alarm` or `irq_pending` is high, but only while both fault pins are high. A wake source raised during a fault is ignored.
- R7: If a battery fault was present when sleep was committed, only GPIO wake lines 0 and 1 end that sleep. `rtc_alarm`, `irq_pending` and the other GPIO lines are ignored.
- R8: On wake with configuration bit 0 set, the block holds mode 5 with `pwr_en` at 0 for OSC_WAIT cycles. It then holds mode 6 with `pwr_en` at 1 for SETTLE cycles, and then enters run. With bit 0 clear, mode 5 is skipped.
- R9: A fault pin low during mode 5 or 6 returns the block to sleep at the next edge.
- R10: Status register 2 is sticky. Each sleep commit sets one cause bit: bit 2 for a battery fault, else bit 1 for a supply fault, else bit 0 for software. Writing 1 to a bit clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wfi_req | input | 1 | Wait-for-interrupt request from the core |
| irq_pending | input | 1 | Qualified interrupt or timer expiry |
| gpio_wake | input | N_WAKE | GPIO wake lines |
| rtc_alarm | input | 1 | RTC alarm wake |
| vdd_fault_n | input | 1 | Supply fault, active low |
| batt_fault_n | input | 1 | Battery fault, active low |
| sr_ack | input | 1 | Memory controller confirms self-refresh |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 config, 2 status) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| mode | output | 3 | Current power mode code |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Memory controller and peripheral clock enable |
| sr_req | output | 1 | Self-refresh request to the memory controller |
| pwr_en | output | 1 | External regulator enable |
| abort_req | output | 1 | Imprecise data abort request to the core |
| osc_pd | output | 1 | Fast oscillator power-down during sleep |
| card_float | output | 1 | Float card-interface controls during sleep |
| cs_float | output | 1 | Float static chip selects during sleep |

## Verification
The bench targets several corner cases. One is a sleep entry whose self-refresh acknowledge arrives late; a design that skips the handshake would gate the memory clock while DRAM is still unprotected. Another is a battery-fault sleep hit by an RTC alarm, an interrupt and an upper GPIO line at once; a design that forgets the lock wakes on the wrong source. The bench also raises a fault midway through power settle, which a careless design would carry on into run with a dead supply. Finally it drives overlapping supply and battery faults under abort mode; a design with the wrong cause priority records a supply fault, or pulses the abort twice.

// File: rtl/pms_pkg.sv
package pms_pkg;

   typedef enum logic [2:0] {
      PM_HWRST   = 3'd0,
      PM_RUN     = 3'd1,
      PM_IDLE    = 3'd2,
      PM_SRENTER = 3'd3,
      PM_SLEEP   = 3'd4,
      PM_WOSC    = 3'd5,
      PM_WPWR    = 3'd6
   } pm_state_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_CFG  = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;

   // cause bit positions in the status register
   localparam int CAUSE_SW   = 0;
   localparam int CAUSE_VDD  = 1;
   localparam int CAUSE_BATT = 2;

endpackage

// File: rtl/pms_regs.sv
module pms_regs
   import pms_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              commit,
   input  logic [2:0]        cause,
   output logic              abort_en,
   output logic              force_sleep,
   output logic [2:0]        cfg,
   output logic [2:0]        status
);

   logic wr_ctrl, wr_cfg, wr_stat;
   logic unused_wdata;

   assign wr_ctrl      = we && (addr == ADDR_CTRL);
   assign wr_cfg       = we && (addr == ADDR_CFG);
   assign wr_stat      = we && (addr == ADDR_STAT);
   assign unused_wdata = ^wdata[DATA_W-1:3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_en    <= 1'b0;
         force_sleep <= 1'b0;
         cfg         <= '0;
         status      <= '0;
      end else begin
         if (wr_ctrl) abort_en <= wdata[0];
         // a commit consumes the request; it wins over a same-cycle write
         if (commit)       force_sleep <= 1'b0;
         else if (wr_ctrl) force_sleep <= wdata[1];
         if (wr_cfg) cfg <= wdata[2:0];
         status <= (wr_stat ? (status & ~wdata[2:0]) : status)
                   | (commit ? cause : 3'b000);
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_CTRL: rdata[1:0] = {force_sleep, abort_en};
         ADDR_CFG:  rdata[2:0] = cfg;
         ADDR_STAT: rdata[2:0] = status;
         default:   rdata      = '0;
      endcase
   end

endmodule

// File: rtl/pms_wake_qual.sv
module pms_wake_qual #(
   parameter int N_WAKE       = 4,
   parameter int LOCKED_LINES = 2
) (
   input  logic [N_WAKE-1:0] gpio_wake,
   input  logic              rtc_alarm,
   input  logic              irq_pending,
   input  logic              vdd_fault_n,
   input  logic              batt_fault_n,
   input  logic              batt_lock,
   output logic              wake,
   output logic              fault_any,
   output logic              vdd_flt,
   output logic              batt_flt
);

   logic [N_WAKE-1:0] lock_mask;

   for (genvar i = 0; i < N_WAKE; i++) begin : g_mask
      assign lock_mask[i] = (i < LOCKED_LINES);
   end

   assign vdd_flt   = !vdd_fault_n;
   assign batt_flt  = !batt_fault_n;
   assign fault_any = vdd_flt || batt_flt;
   assign wake      = batt_lock ? (|(gpio_wake & lock_mask))
                                : ((|gpio_wake) || rtc_alarm || irq_pending);

endmodule

// File: rtl/pms_delay.sv
module pms_delay #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/pms_sequencer.sv
module pms_sequencer
   import pms_pkg::*;
#(
   parameter int N_WAKE       = 4,
   parameter int LOCKED_LINES = 2,
   parameter int OSC_WAIT     = 8,
   parameter int SETTLE       = 4,
   parameter int DATA_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wfi_req,
   input  logic              irq_pending,
   input  logic [N_WAKE-1:0] gpio_wake,
   input  logic              rtc_alarm,
   input  logic              vdd_fault_n,
   input  logic              batt_fault_n,
   input  logic              sr_ack,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [2:0]        mode,
   output logic              cpu_clk_en,
   output logic              per_clk_en,
   output logic              sr_req,
   output logic              pwr_en,
   output logic              abort_req,
   output logic              osc_pd,
   output logic              card_float,
   output logic              cs_float
);

   localparam int DLY_MAX = (OSC_WAIT > SETTLE) ? OSC_WAIT : SETTLE;
   localparam int DLY_W   = $clog2(DLY_MAX + 1);
   localparam logic [DLY_W-1:0] OSC_LD = DLY_W'(OSC_WAIT - 1);
   localparam logic [DLY_W-1:0] SET_LD = DLY_W'(SETTLE - 1);

   initial begin
      assert (N_WAKE >= LOCKED_LINES && LOCKED_LINES >= 1)
         else $error("pms_sequencer: LOCKED_LINES must be 1..N_WAKE");
      assert (OSC_WAIT >= 1 && SETTLE >= 1)
         else $error("pms_sequencer: wait counts must be at least 1");
      assert (DATA_W >= 4)
         else $error("pms_sequencer: DATA_W must be at least 4");
   end

   pm_state_t        state, nxt;
   logic             commit;
   logic [2:0]       cause;
   logic             abort_en, force_sleep;
   logic [2:0]       cfg;
   logic [2:0]       status;
   logic             wake, fault_any, vdd_flt, batt_flt;
   logic             fault_q, fault_rise;
   logic             batt_lock;
   logic             dly_load, dly_done;
   logic [DLY_W-1:0] dly_val;
   logic             abort_q;
   logic             unused_status;

   assign unused_status = ^status;

   pms_regs #(.DATA_W(DATA_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (reg_we),
      .addr        (reg_addr),
      .wdata       (reg_wdata),
      .rdata       (reg_rdata),
      .commit      (commit),
      .cause       (cause),
      .abort_en    (abort_en),
      .force_sleep (force_sleep),
      .cfg         (cfg),
      .status      (status)
   );

   pms_wake_qual #(.N_WAKE(N_WAKE), .LOCKED_LINES(LOCKED_LINES)) u_wake (
      .gpio_wake    (gpio_wake),
      .rtc_alarm    (rtc_alarm),
      .irq_pending  (irq_pending),
      .vdd_fault_n  (vdd_fault_n),
      .batt_fault_n (batt_fault_n),
      .batt_lock    (batt_lock),
      .wake         (wake),
      .fault_any    (fault_any),
      .vdd_flt      (vdd_flt),
      .batt_flt     (batt_flt)
   );

   pms_delay #(.W(DLY_W)) u_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dly_load),
      .load_val (dly_val),
      .done     (dly_done)
   );

   assign fault_rise = fault_any && !fault_q;

   // cause priority: battery, then supply, then software
   always_comb begin
      cause = 3'b000;
      if (batt_flt)     cause[CAUSE_BATT] = 1'b1;
      else if (vdd_flt) cause[CAUSE_VDD]  = 1'b1;
      else              cause[CAUSE_SW]   = 1'b1;
   end

   always_comb begin
      nxt      = state;
      commit   = 1'b0;
      dly_load = 1'b0;
      dly_val  = '0;
      case (state)
         PM_HWRST: nxt = PM_RUN;
         PM_RUN: begin
            if ((fault_any && !abort_en) || force_sleep) begin
               nxt    = PM_SRENTER;
               commit = 1'b1;
            end else if (wfi_req) begin
               nxt = PM_IDLE;
            end
         end
         PM_IDLE: begin
            if (fault_any && !abort_en) begin
               nxt    = PM_SRENTER;
               commit = 1'b1;
            end else if ((abort_en && fault_rise) || irq_pending) begin
               nxt = PM_RUN;
            end
         end
         PM_SRENTER: if (sr_ack) nxt = PM_SLEEP;
         PM_SLEEP: begin
            if (!fault_any && wake) begin
               dly_load = 1'b1;
               if (cfg[0]) begin
                  nxt     = PM_WOSC;
                  dly_val = OSC_LD;
               end else begin
                  nxt     = PM_WPWR;
                  dly_val = SET_LD;
               end
            end
         end
         PM_WOSC: begin
            if (fault_any) begin
               nxt    = PM_SLEEP;
               commit = 1'b1;
            end else if (dly_done) begin
               nxt      = PM_WPWR;
               dly_load = 1'b1;
               dly_val  = SET_LD;
            end
         end
         PM_WPWR: begin
            if (fault_any) begin
               nxt    = PM_SLEEP;
               commit = 1'b1;
            end else if (dly_done) begin
               nxt = PM_RUN;
            end
         end
         default: nxt = PM_HWRST;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PM_HWRST;
         fault_q   <= 1'b0;
         abort_q   <= 1'b0;
         batt_lock <= 1'b0;
      end else begin
         state     <= nxt;
         fault_q   <= fault_any;
         abort_q   <= ((state == PM_RUN) || (state == PM_IDLE)) && abort_en && fault_rise;
         if (commit) batt_lock <= batt_flt;
      end
   end

   always_comb begin
      cpu_clk_en = 1'b0;
      per_clk_en = 1'b0;
      sr_req     = 1'b0;
      pwr_en     = 1'b1;
      case (state)
         PM_RUN:     begin cpu_clk_en = 1'b1; per_clk_en = 1'b1; end
         PM_IDLE:    per_clk_en = 1'b1;
         PM_SRENTER: begin per_clk_en = 1'b1; sr_req = 1'b1; end
         PM_SLEEP:   begin sr_req = 1'b1; pwr_en = 1'b0; end
         PM_WOSC:    begin sr_req = 1'b1; pwr_en = 1'b0; end
         PM_WPWR:    sr_req = 1'b1;
         default:    ;
      endcase
   end

   assign mode       = state;
   assign abort_req  = abort_q;
   assign osc_pd     = cfg[0] && (state == PM_SLEEP);
   assign card_float = cfg[1] && (state == PM_SLEEP);
   assign cs_float   = cfg[2] && (state == PM_SLEEP);

endmodule

// File: rtl/pms_sequencer_chk.sv
module pms_sequencer_chk
   import pms_pkg::*;
#(
   parameter int N_WAKE = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode,
   input logic              cpu_clk_en,
   input logic              per_clk_en,
   input logic              pwr_en,
   input logic              sr_req,
   input logic              sr_ack,
   input logic              abort_req,
   input logic              vdd_fault_n,
   input logic              batt_fault_n,
   input logic [N_WAKE-1:0] gpio_wake,
   input logic              batt_lock
);

   assert_idle_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_IDLE) |-> (!cpu_clk_en && per_clk_en));

   assert_sleep_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_SLEEP && $past(mode) == PM_SRENTER) |-> $past(sr_ack));

   assert_sleep_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_SLEEP) |-> (!pwr_en && !per_clk_en && !cpu_clk_en && sr_req));

   assert_abort_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |=> !abort_req);

   assert_batt_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_SLEEP && batt_lock && gpio_wake[1:0] == 2'b00) |=> (mode == PM_SLEEP));

   assert_wake_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == PM_WOSC || mode == PM_WPWR) && (!vdd_fault_n || !batt_fault_n))
      |=> (mode == PM_SLEEP));

endmodule

bind pms_sequencer pms_sequencer_chk #(.N_WAKE(N_WAKE)) u_chk (.*);

// File: tb/pms_sequencer_tb.sv
module pms_sequencer_tb;

   localparam int N_WAKE   = 4;
   localparam int OSC_WAIT = 8;
   localparam int SETTLE   = 4;
   localparam int DATA_W   = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              wfi_req = 0, irq_pending = 0, rtc_alarm = 0;
   logic [N_WAKE-1:0] gpio_wake = '0;
   logic              vdd_fault_n = 1, batt_fault_n = 1, sr_ack = 1;
   logic              reg_we = 0;
   logic [1:0]        reg_addr = 0;
   logic [DATA_W-1:0] reg_wdata = 0;
   logic [DATA_W-1:0] reg_rdata;
   logic [2:0]        mode;
   logic cpu_clk_en, per_clk_en, sr_req, pwr_en, abort_req, osc_pd, card_float, cs_float;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   pms_sequencer #(.N_WAKE(N_WAKE), .OSC_WAIT(OSC_WAIT), .SETTLE(SETTLE), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .irq_pending(irq_pending),
      .gpio_wake(gpio_wake), .rtc_alarm(rtc_alarm), .vdd_fault_n(vdd_fault_n),
      .batt_fault_n(batt_fault_n), .sr_ack(sr_ack), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode(mode), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .sr_req(sr_req), .pwr_en(pwr_en), .abort_req(abort_req),
      .osc_pd(osc_pd), .card_float(card_float), .cs_float(cs_float));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_state = 0, m_wait = 0, m_cfg = 0, m_status = 0;
   bit m_force = 0, m_ab = 0, m_lock = 0, m_fq = 0, m_abort = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_wait = 0; m_cfg = 0; m_status = 0;
         m_force = 0; m_ab = 0; m_lock = 0; m_fq = 0; m_abort = 0;
      end else begin
         bit fault, rise, go_sleep, batt, vdd, wk;
         int ns, nw, cz;
         batt = !batt_fault_n;
         vdd  = !vdd_fault_n;
         fault = batt || vdd;
         rise  = fault && !m_fq;
         wk = m_lock ? (gpio_wake[1:0] != 0) : (gpio_wake != 0 || rtc_alarm || irq_pending);
         ns = m_state; nw = m_wait; go_sleep = 0;
         m_abort = (m_state == 1 || m_state == 2) && m_ab && rise;
         if (m_state == 0) ns = 1;
         else if (m_state == 1) begin
            if ((fault && !m_ab) || m_force) begin ns = 3; go_sleep = 1; end
            else if (wfi_req) ns = 2;
         end else if (m_state == 2) begin
            if (fault && !m_ab) begin ns = 3; go_sleep = 1; end
            else if ((m_ab && rise) || irq_pending) ns = 1;
         end else if (m_state == 3) begin
            if (sr_ack) ns = 4;
         end else if (m_state == 4) begin
            if (!fault && wk) begin
               if (m_cfg % 2 == 1) begin ns = 5; nw = OSC_WAIT; end
               else begin ns = 6; nw = SETTLE; end
            end
         end else begin
            if (fault) begin ns = 4; go_sleep = 1; end
            else if (m_wait <= 1) begin
               if (m_state == 5) begin ns = 6; nw = SETTLE; end
               else ns = 1;
            end else nw = m_wait - 1;
         end
         cz = batt ? 4 : (vdd ? 2 : 1);
         if (reg_we && reg_addr == 2) m_status = m_status & ~int'(reg_wdata[2:0]);
         if (go_sleep) begin m_status = m_status | cz; m_lock = batt; end
         if (reg_we && reg_addr == 0) m_ab = reg_wdata[0];
         if (go_sleep) m_force = 0;
         else if (reg_we && reg_addr == 0) m_force = reg_wdata[1];
         if (reg_we && reg_addr == 1) m_cfg = int'(reg_wdata[2:0]);
         m_fq = fault;
         m_state = ns;
         m_wait = nw;
      end
   end

   function automatic string mode_tag(int s);
      case (s)
         0: return "R1";
         1, 2: return "R2";
         3: return "R3";
         4: return "R4";
         default: return "R8";
      endcase
   endfunction

   function automatic int exp_gates(int s);
      // {cpu, per, sr, pwr}
      case (s)
         0: return 4'b0001;
         1: return 4'b1101;
         2: return 4'b0101;
         3: return 4'b0111;
         4: return 4'b0010;
         5: return 4'b0010;
         default: return 4'b0011;
      endcase
   endfunction

   function automatic int exp_rdata(int a);
      case (a)
         0: return {m_force, m_ab};
         1: return m_cfg;
         2: return m_status;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      #5;
      chk(mode_tag(m_state), mode, m_state);
      chk("R4 gates", {cpu_clk_en, per_clk_en, sr_req, pwr_en}, exp_gates(m_state));
      chk("R5 abort", abort_req, m_abort);
      chk("R4 floats", {cs_float, card_float, osc_pd}, (m_state == 4) ? m_cfg : 0);
      chk("R10 rdata", reg_rdata, exp_rdata(reg_addr));
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      reg_we = 1; reg_addr = a[1:0]; reg_wdata = d[DATA_W-1:0];
      step(1);
      reg_we = 0;
   endtask

   task automatic rd(input string tag, input int a, input int exp);
      reg_addr = a[1:0];
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   initial begin
      rst_n = 1'b0;
      step(3);
      // R1 reset state
      chk("R1 mode", mode, 0);
      chk("R1 pwr_en", pwr_en, 1);
      chk("R1 cpu_clk_en", cpu_clk_en, 0);
      rd("R1 status", 2, 0);
      rst_n = 1'b1;
      step(1);
      chk("R1 run after release", mode, 1);

      // R2 idle entry/exit; irq in run is ignored
      irq_pending = 1; step(1); irq_pending = 0;
      chk("R2 irq in run", mode, 1);
      wfi_req = 1; step(1); wfi_req = 0;
      chk("R2 idle", mode, 2);
      chk("R2 idle cpu clk", cpu_clk_en, 0);
      chk("R2 idle per clk", per_clk_en, 1);
      step(3);
      chk("R2 stays idle", mode, 2);
      irq_pending = 1; step(1); irq_pending = 0;
      chk("R2 irq wakes idle", mode, 1);

      // R3/R4/R8 software sleep with late ack and oscillator wait
      wr(1, 7);
      sr_ack = 0;
      wr(0, 2);
      step(1);
      chk("R3 sleep entry", mode, 3);
      chk("R3 sr_req", sr_req, 1);
      step(3);
      chk("R3 waits for ack", mode, 3);
      rd("R3 force cleared", 0, 0);
      sr_ack = 1; step(1);
      chk("R4 sleep", mode, 4);
      chk("R4 pwr_en low", pwr_en, 0);
      chk("R4 floats", {cs_float, card_float, osc_pd}, 7);
      rd("R10 sw cause", 2, 1);
      rtc_alarm = 1; step(1); rtc_alarm = 0;
      chk("R8 osc wait", mode, 5);
      chk("R8 pwr_en off in osc wait", pwr_en, 0);
      step(7);
      chk("R8 osc wait length", mode, 5);
      step(1);
      chk("R8 settle", mode, 6);
      chk("R8 pwr_en on", pwr_en, 1);
      step(3);
      chk("R8 settle length", mode, 6);
      step(1);
      chk("R8 back to run", mode, 1);

      // R10 write-one-to-clear
      wr(2, 1);
      rd("R10 cleared", 2, 0);
      wr(1, 0);

      // supply fault, R6 ignore during fault, R9 fault in settle
      vdd_fault_n = 0; step(1);
      chk("R3 fault sleep entry", mode, 3);
      step(1);
      chk("R4 fault sleep", mode, 4);
      rd("R10 vdd cause", 2, 2);
      gpio_wake = 4'b1000; step(2);
      chk("R6 wake ignored in fault", mode, 4);
      gpio_wake = 0; vdd_fault_n = 1; step(2);
      chk("R6 no spurious wake", mode, 4);
      gpio_wake = 4'b1000; step(1); gpio_wake = 0;
      chk("R8 osc wait skipped", mode, 6);
      step(1);
      vdd_fault_n = 0; step(1);
      chk("R9 fault in settle", mode, 4);
      vdd_fault_n = 1; step(1);
      irq_pending = 1; step(1); irq_pending = 0;
      chk("R6 irq wake", mode, 6);
      step(4);
      chk("R6 run after irq wake", mode, 1);

      // R7 battery fault from idle
      wr(2, 7);
      wfi_req = 1; step(1); wfi_req = 0;
      batt_fault_n = 0; step(1);
      chk("R3 idle fault entry", mode, 3);
      step(1);
      chk("R4 batt sleep", mode, 4);
      batt_fault_n = 1;
      rd("R10 batt cause", 2, 4);
      rtc_alarm = 1; irq_pending = 1; gpio_wake = 4'b1100; step(3);
      chk("R7 locked sleep", mode, 4);
      rtc_alarm = 0; irq_pending = 0; gpio_wake = 4'b0010; step(1); gpio_wake = 0;
      chk("R7 gpio1 wakes", mode, 6);
      step(4);
      chk("R7 run", mode, 1);

      // R5 abort mode, then software sleep with both faults
      wr(2, 7);
      wr(0, 1);
      vdd_fault_n = 0; step(1);
      chk("R5 abort pulse", abort_req, 1);
      chk("R5 no sleep", mode, 1);
      step(1);
      chk("R5 single pulse", abort_req, 0);
      wfi_req = 1; step(1); wfi_req = 0;
      chk("R5 idle with held fault", mode, 2);
      vdd_fault_n = 1; step(1);
      vdd_fault_n = 0; batt_fault_n = 0; step(1);
      chk("R5 idle abort to run", mode, 1);
      chk("R5 idle abort pulse", abort_req, 1);
      wr(0, 3);
      step(1);
      chk("R3 sw entry after abort", mode, 3);
      step(1);
      chk("R4 sleep after abort", mode, 4);
      rd("R10 batt priority", 2, 4);
      vdd_fault_n = 1; batt_fault_n = 1;
      gpio_wake = 4'b0001; step(1); gpio_wake = 0;
      chk("R7 gpio0 wakes", mode, 6);
      step(4);
      chk("R8 run at end", mode, 1);
      step(2);

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule